// File: doc/BRIEF.md
# ISA Memory Cycle Front End with Wait-State Generation

This block is the bus-facing front end of a peripheral that sits on an AT-style memory bus. The upper address bits arrive on the bus without a latch. The block holds them in two stages in series. The first stage is a transparent latch that is open while the address-latch-enable input is high. The second stage is a register that loads on the leading, falling edge of the memory read or memory write strobe. Both wiring options therefore work. With the enable pulsed, the address is held from the moment the enable falls. With the enable tied high, the first stage stays open and the strobe edge alone holds the address. The enable must be tied high in 8-bit systems.

The held address is decoded into one of four targets: on-chip RAM, internal registers, PROM, and external registers. The select for that target is driven while the strobe is active. On reads, the data of the selected target is returned. When the wait-state configuration bit is set, the block synchronizes the strobe into the local crystal clock domain. On the synchronized falling edge it drives the bus ready line low for a fixed count of local clocks. The ready line is modelled as an active-high drive-low enable, so releasing it means driving 0 on that enable. This stretch is the same for every target and does not depend on the PROM enable.

Top module: `isa_mem_front`

## Requirements
- R1: With the latch enable pulsed high and then low before the strobe, the held address equals the bus address present when the enable fell. Bus address changes after the enable falls are ignored.
- R2: With the latch enable held high, the held address equals the bus address present at the falling edge of the read or write strobe.
- R3: After the strobe's falling edge, changes on the address bus do not alter `cap_addr_o` for the rest of that cycle.
- R4: The two most significant held address bits select the target: 00 RAM, 01 internal register, 10 PROM, 11 external register.
- R5: When `prom_en_i` is 0, region 10 selects the external register target instead of the PROM.
- R6: While either strobe is low, exactly one select output is 1. While both strobes are high, all selects are 0.
- R7: `rdata_o` carries the selected target's read data while `memr_ni` is low, and is 0 otherwise, including during write cycles.
- R8: When `wait_en_i` is 0, `rdy_low_o` stays 0 through every cycle type.
- R9: When `wait_en_i` is 1, `rdy_low_o` rises at the third rising edge of `clk_i` after the strobe's falling edge. That is 2 to 3 clock periods after the strobe, depending on phase.
- R10: `rdy_low_o` stays high for exactly LOW_CYCLES (default 2) clocks and then returns to 0. This length is the same for all four targets and for both values of `prom_en_i`.
- R11: After reset, all selects, `rdy_low_o`, `rdata_o` and `cap_addr_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Local crystal clock used to time the wait state |
| rst_ni | input | 1 | Asynchronous active-low reset |
| addr_i | input | ADDR_W | Unlatched bus address bits |
| bale_i | input | 1 | Address latch enable; first stage is transparent while high |
| memr_ni | input | 1 | Memory read strobe, active low |
| memw_ni | input | 1 | Memory write strobe, active low |
| wait_en_i | input | 1 | Configuration bit enabling the wait state |
| prom_en_i | input | 1 | PROM decode enable |
| ram_rdata_i | input | DATA_W | Read data from RAM |
| reg_rdata_i | input | DATA_W | Read data from internal registers |
| prom_rdata_i | input | DATA_W | Read data from PROM |
| ext_rdata_i | input | DATA_W | Read data from external registers |
| cap_addr_o | output | ADDR_W | Address held by the second stage |
| sel_ram_o | output | 1 | RAM select |
| sel_reg_o | output | 1 | Internal register select |
| sel_prom_o | output | 1 | PROM select |
| sel_ext_o | output | 1 | External register select |
| rdata_o | output | DATA_W | Read data returned to the bus |
| rdy_low_o | output | 1 | Drive-low enable for the bus ready line |

## Verification
The hardest situation to create is one where the address bus holds a different value at the strobe edge than the one the block must keep. The stimulus changes the bus right after the latch enable falls, in pulsed mode, and right after the strobe falls, in tied-high mode. Only then does a wrong latch stage show up on `cap_addr_o`. The wait-state start depends on the strobe's phase against the local clock. The stimulus therefore always drops the strobe 5 ns after a rising edge, which makes the onset edge deterministic. It then samples `rdy_low_o` after each of the following six edges, for every target and for both PROM enable values.

// File: rtl/isa_fe_pkg.sv
package isa_fe_pkg;

    typedef enum logic [1:0] {
        RG_RAM  = 2'b00,
        RG_REG  = 2'b01,
        RG_PROM = 2'b10,
        RG_EXT  = 2'b11
    } region_e;

    typedef struct packed {
        logic ram;
        logic regf;
        logic prom;
        logic ext;
    } sel_t;

endpackage

// File: rtl/isa_addr_capture.sv
module isa_addr_capture #(
    parameter int unsigned ADDR_W = 16
) (
    input  logic              rst_ni,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              bale_i,
    input  logic              strb_ni,
    output logic [ADDR_W-1:0] cap_addr_o
);

    logic [ADDR_W-1:0] stage1_q;
    logic [ADDR_W-1:0] stage2_d, stage2_q;

    // First stage: open while the latch enable is high; tied high = always open
    always_latch begin
        if (bale_i) begin
            stage1_q = addr_i;
        end
    end

    always_comb begin
        stage2_d = stage1_q;
    end

    // Second stage: loads on the leading edge of the combined strobe
    always_ff @(negedge strb_ni or negedge rst_ni) begin
        if (!rst_ni) begin
            stage2_q <= '0;
        end else begin
            stage2_q <= stage2_d;
        end
    end

    assign cap_addr_o = stage2_q;

endmodule

// File: rtl/isa_cycle_decode.sv
module isa_cycle_decode
    import isa_fe_pkg::*;
#(
    parameter int unsigned DATA_W = 8
) (
    input  logic [1:0]        region_i,
    input  logic              strb_act_i,
    input  logic              rd_act_i,
    input  logic              prom_en_i,
    input  logic [DATA_W-1:0] ram_rdata_i,
    input  logic [DATA_W-1:0] reg_rdata_i,
    input  logic [DATA_W-1:0] prom_rdata_i,
    input  logic [DATA_W-1:0] ext_rdata_i,
    output sel_t              sel_o,
    output logic [DATA_W-1:0] rdata_o
);

    region_e region;
    sel_t    hit;

    always_comb begin
        region = region_e'(region_i);
        hit    = '0;
        unique case (region)
            RG_RAM:  hit.ram  = 1'b1;
            RG_REG:  hit.regf = 1'b1;
            RG_PROM: begin
                if (prom_en_i) hit.prom = 1'b1;
                else           hit.ext  = 1'b1;
            end
            RG_EXT:  hit.ext  = 1'b1;
            default: hit      = '0;
        endcase
    end

    always_comb begin
        sel_o   = strb_act_i ? hit : '0;
        rdata_o = '0;
        if (rd_act_i) begin
            if (hit.ram)  rdata_o = ram_rdata_i;
            if (hit.regf) rdata_o = reg_rdata_i;
            if (hit.prom) rdata_o = prom_rdata_i;
            if (hit.ext)  rdata_o = ext_rdata_i;
        end
    end

endmodule

// File: rtl/isa_wait_gen.sv
module isa_wait_gen #(
    parameter int unsigned LOW_CYCLES = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic strb_ni,
    input  logic wait_en_i,
    output logic rdy_low_o
);

    localparam int unsigned CNT_W = (LOW_CYCLES < 2) ? 1 : $clog2(LOW_CYCLES);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(LOW_CYCLES - 1);

    typedef struct packed {
        logic             s1;
        logic             s2;
        logic             s3;
        logic             busy;
        logic [CNT_W-1:0] cnt;
    } wg_state_t;

    wg_state_t st_d, st_q;
    logic      fall;

    always_comb begin
        st_d    = st_q;
        st_d.s1 = strb_ni;
        st_d.s2 = st_q.s1;
        st_d.s3 = st_q.s2;
        fall    = st_q.s3 & ~st_q.s2;
        if (st_q.busy) begin
            st_d.cnt = st_q.cnt + 1'b1;
            if (st_q.cnt == LAST) begin
                st_d.busy = 1'b0;
                st_d.cnt  = '0;
            end
        end else if (fall && wait_en_i) begin
            st_d.busy = 1'b1;
            st_d.cnt  = '0;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '{s1: 1'b1, s2: 1'b1, s3: 1'b1, busy: 1'b0, cnt: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign rdy_low_o = st_q.busy;

endmodule

// File: rtl/isa_mem_front.sv
module isa_mem_front
    import isa_fe_pkg::*;
#(
    parameter int unsigned ADDR_W     = 16,
    parameter int unsigned DATA_W     = 8,
    parameter int unsigned LOW_CYCLES = 2
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              bale_i,
    input  logic              memr_ni,
    input  logic              memw_ni,
    input  logic              wait_en_i,
    input  logic              prom_en_i,
    input  logic [DATA_W-1:0] ram_rdata_i,
    input  logic [DATA_W-1:0] reg_rdata_i,
    input  logic [DATA_W-1:0] prom_rdata_i,
    input  logic [DATA_W-1:0] ext_rdata_i,
    output logic [ADDR_W-1:0] cap_addr_o,
    output logic              sel_ram_o,
    output logic              sel_reg_o,
    output logic              sel_prom_o,
    output logic              sel_ext_o,
    output logic [DATA_W-1:0] rdata_o,
    output logic              rdy_low_o
);

    logic strb_n;
    sel_t sel;

    assign strb_n = memr_ni & memw_ni;

    isa_addr_capture #(.ADDR_W(ADDR_W)) u_cap (
        .rst_ni     (rst_ni),
        .addr_i     (addr_i),
        .bale_i     (bale_i),
        .strb_ni    (strb_n),
        .cap_addr_o (cap_addr_o)
    );

    isa_cycle_decode #(.DATA_W(DATA_W)) u_dec (
        .region_i     (cap_addr_o[ADDR_W-1 -: 2]),
        .strb_act_i   (~strb_n),
        .rd_act_i     (~memr_ni),
        .prom_en_i    (prom_en_i),
        .ram_rdata_i  (ram_rdata_i),
        .reg_rdata_i  (reg_rdata_i),
        .prom_rdata_i (prom_rdata_i),
        .ext_rdata_i  (ext_rdata_i),
        .sel_o        (sel),
        .rdata_o      (rdata_o)
    );

    isa_wait_gen #(.LOW_CYCLES(LOW_CYCLES)) u_wait (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .strb_ni   (strb_n),
        .wait_en_i (wait_en_i),
        .rdy_low_o (rdy_low_o)
    );

    assign sel_ram_o  = sel.ram;
    assign sel_reg_o  = sel.regf;
    assign sel_prom_o = sel.prom;
    assign sel_ext_o  = sel.ext;

endmodule

// File: rtl/isa_mem_front_chk.sv
module isa_mem_front_chk #(
    parameter int unsigned DATA_W = 8
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic              memr_ni,
    input logic              memw_ni,
    input logic              wait_en_i,
    input logic              sel_ram_o,
    input logic              sel_reg_o,
    input logic              sel_prom_o,
    input logic              sel_ext_o,
    input logic [DATA_W-1:0] rdata_o,
    input logic              rdy_low_o
);

    // R6
    sel_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!memr_ni || !memw_ni) |-> $countones({sel_ram_o, sel_reg_o, sel_prom_o, sel_ext_o}) == 1);

    // R6
    sel_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (memr_ni && memw_ni) |-> ({sel_ram_o, sel_reg_o, sel_prom_o, sel_ext_o} == 4'b0));

    // R7
    rdata_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        memr_ni |-> (rdata_o == '0));

    // R8
    wait_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(rdy_low_o) |-> $past(wait_en_i));

    // R10
    low_min_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(rdy_low_o) |=> rdy_low_o);

endmodule

bind isa_mem_front isa_mem_front_chk #(.DATA_W(DATA_W)) u_chk (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .memr_ni    (memr_ni),
    .memw_ni    (memw_ni),
    .wait_en_i  (wait_en_i),
    .sel_ram_o  (sel_ram_o),
    .sel_reg_o  (sel_reg_o),
    .sel_prom_o (sel_prom_o),
    .sel_ext_o  (sel_ext_o),
    .rdata_o    (rdata_o),
    .rdy_low_o  (rdy_low_o)
);

// File: tb/tb_isa_mem_front.sv
`timescale 1ns/1ps
module tb_isa_mem_front;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] addr = '0;
    logic        bale = 1'b1;
    logic        memr_n = 1'b1;
    logic        memw_n = 1'b1;
    logic        wait_en = 1'b0;
    logic        prom_en = 1'b1;
    logic [7:0]  cap_unused;
    logic [15:0] cap_addr;
    logic        s_ram, s_reg, s_prom, s_ext;
    logic [7:0]  rdata;
    logic        rdy_low;
    int          n_vec = 0;
    int          n_bad = 0;
    bit          done = 1'b0;

    localparam logic [7:0] D_RAM = 8'h11, D_REG = 8'h22, D_PROM = 8'h33, D_EXT = 8'h44;

    always #10 clk = ~clk;

    isa_mem_front dut (
        .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .bale_i(bale),
        .memr_ni(memr_n), .memw_ni(memw_n), .wait_en_i(wait_en), .prom_en_i(prom_en),
        .ram_rdata_i(D_RAM), .reg_rdata_i(D_REG), .prom_rdata_i(D_PROM), .ext_rdata_i(D_EXT),
        .cap_addr_o(cap_addr), .sel_ram_o(s_ram), .sel_reg_o(s_reg), .sel_prom_o(s_prom),
        .sel_ext_o(s_ext), .rdata_o(rdata), .rdy_low_o(rdy_low)
    );

    assign cap_unused = '0;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [3:0] exp_sel(input logic [15:0] a, input logic pe);
        case (a[15:14])
            2'b00:   return 4'b1000;
            2'b01:   return 4'b0100;
            2'b10:   return pe ? 4'b0010 : 4'b0001;
            default: return 4'b0001;
        endcase
    endfunction

    function automatic logic [7:0] exp_data(input logic [3:0] s);
        case (s)
            4'b1000: return D_RAM;
            4'b0100: return D_REG;
            4'b0010: return D_PROM;
            default: return D_EXT;
        endcase
    endfunction

    // One bus cycle. pulsed: enable pulsed then bus scrambled before strobe
    task automatic bus_cycle(input string tag, input logic [15:0] a, input bit pulsed,
                             input bit rd, input bit we, input logic pe);
        logic [3:0] es;
        bit         ek;
        es = exp_sel(a, pe);
        @(posedge clk);
        #1;
        wait_en = we; prom_en = pe; addr = a; bale = 1'b1;
        #2;
        if (pulsed) bale = 1'b0;
        #1;
        if (pulsed) addr = ~a;
        #1;
        if (rd) memr_n = 1'b0; else memw_n = 1'b0;
        #2;
        addr = a ^ 16'h3C3C;
        for (int k = 1; k <= 6; k++) begin
            @(posedge clk);
            #1;
            ek = we && (k == 3 || k == 4);
            check({tag, pulsed ? " R9 R10 ready(pulsed)" : " R9 R10 ready"}, 32'(rdy_low), 32'(ek));
            if (k == 1) begin
                check({tag, pulsed ? " R1 captured" : " R2 captured"}, 32'(cap_addr), 32'(a));
                check({tag, " R4 R5 R6 selects"}, 32'({s_ram, s_reg, s_prom, s_ext}), 32'(es));
                check({tag, " R7 rdata"}, 32'(rdata), rd ? 32'(exp_data(es)) : 32'h0);
            end
        end
        check({tag, " R3 hold after strobe"}, 32'(cap_addr), 32'(a));
        memr_n = 1'b1; memw_n = 1'b1;
        #1;
        check({tag, " R6 idle selects"}, 32'({s_ram, s_reg, s_prom, s_ext}), 32'h0);
        check({tag, " R7 idle rdata"}, 32'(rdata), 32'h0);
        bale = pulsed ? 1'b0 : 1'b1;
        repeat (4) @(posedge clk);
    endtask

    task automatic t_reset;
        #1;
        check("R11 reset selects", 32'({s_ram, s_reg, s_prom, s_ext}), 32'h0);
        check("R11 reset ready", 32'(rdy_low), 32'h0);
        check("R11 reset rdata", 32'(rdata), 32'h0);
        check("R11 reset addr", 32'(cap_addr), 32'h0);
    endtask

    task automatic t_pulsed;
        bus_cycle("pulsed RAM rd",  16'h0123, 1'b1, 1'b1, 1'b1, 1'b1);
        bus_cycle("pulsed REG rd",  16'h4ABC, 1'b1, 1'b1, 1'b1, 1'b1);
        bus_cycle("pulsed PROM rd", 16'h8001, 1'b1, 1'b1, 1'b1, 1'b1);
        bus_cycle("pulsed EXT wr",  16'hC0FF, 1'b1, 1'b0, 1'b1, 1'b1);
    endtask

    task automatic t_tied_high;
        bus_cycle("high RAM wr",  16'h2468, 1'b0, 1'b0, 1'b1, 1'b1);
        bus_cycle("high EXT rd",  16'hF00D, 1'b0, 1'b1, 1'b1, 1'b1);
        bus_cycle("high REG rd",  16'h7777, 1'b0, 1'b1, 1'b1, 1'b0);
    endtask

    task automatic t_prom_off;
        bus_cycle("R5 PROM off rd", 16'hA5A5, 1'b0, 1'b1, 1'b1, 1'b0);
        bus_cycle("R5 PROM off pulsed", 16'h9000, 1'b1, 1'b1, 1'b1, 1'b0);
    endtask

    task automatic t_wait_off;
        bus_cycle("R8 nowait RAM",  16'h0010, 1'b0, 1'b1, 1'b0, 1'b1);
        bus_cycle("R8 nowait PROM", 16'h8888, 1'b1, 1'b1, 1'b0, 1'b1);
        bus_cycle("R8 nowait EXT",  16'hDEAD, 1'b0, 1'b0, 1'b0, 1'b0);
    endtask

    initial begin
        #1;
        addr = 16'h0000;
        repeat (3) @(posedge clk);
        t_reset();
        #4 rst_n = 1'b1;
        repeat (3) @(posedge clk);
        t_pulsed();
        t_tied_high();
        t_prom_off();
        t_wait_off();
        if (!done) begin
            done = 1'b1;
            $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        #200000;
        if (!done) begin
            done = 1'b1;
            n_vec++;
            n_bad++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

endmodule